// File: doc/BRIEF.md
# Four-Port GPIO Register Block

This block is a byte-wide, memory-mapped register file for four 8-bit general-purpose I/O ports. Each port has an output latch, an output-mode register, a direction register and a read-only pin-input register. Two pin-function select registers sit alongside them, one for port 2 and one for port 4. A simple register bus reaches the block. It carries an address, separate read and write strobes, an access-size code and write data, and it returns registered read data and a one-cycle error pulse.

The address map is sparse and split into banks. Every register has its own mask of writable bits. A write that would set any read-only bit is rejected whole: the target keeps its old value and the error flag pulses. The same error is raised for unmapped offsets, for access sizes other than one byte, for writes to pin-input registers, and for a cycle that asserts both strobes.

The output latches drive the pad output values directly, and the direction registers drive the pad output enables directly. The external pin buses pass through a two-flop synchronizer before they can be read.

Top module: `gpio4_regfile`

## Requirements
- R1: Offsets decode as follows, with the port number taken from the low offset bits. Ports 0, 1, 2 and 3 sit at low byte 0x0, 0x1, 0x4 and 0x5 within each bank. The output bank base is 0x00, the mode bank base is 0x20, the direction bank base is 0x60 and the pin bank base is 0x80. The port-2 select register is at 0x44 and the port-4 select register is at 0x48. A legal write to a register followed by a legal read returns the written byte.
- R2: A read or write at any offset outside that set of 18 raises the error flag, returns read data 0 and changes no register.
- R3: The size code 2'b00 means a single byte and is the only legal code. Any other code raises the error flag and changes no register.
- R4: After reset, all output, direction and pin-input registers read 0x00. The mode registers of ports 0, 1 and 3 read 0x00 and the port-2 mode register reads 0xFF. The port-2 select register reads 0x00 and the port-4 select register reads 0x0F.
- R5: For port 3, only bits 1:0 of the output, mode and direction registers are writable. A write with any of bits 7:2 set is rejected and flagged.
- R6: For ports 0 and 1, only bit 0 of the mode register is writable. A mode write with any of bits 7:1 set is rejected and flagged. The port-2 mode register accepts all 8 bits.
- R7: The pin-input registers are read-only. Any write to them raises the error flag.
- R8: The port-2 select register accepts only bits 1:0 and the port-4 select register accepts only bits 3:0. A write that sets a higher bit is rejected and flagged.
- R9: A rejected write leaves its target holding its previous value, with no partial masking of the legal bits.
- R10: A pin-input read returns the external pin bus as sampled through two flops. A read strobed at clock edge k returns the pin value present at edge k-2. Reads of all four pin registers are legal.
- R11: pin_out carries the four output registers, with port p in bits 8p+7:8p. pin_oe carries the four direction registers in the same layout, where 1 means output.
- R12: Read data and the error flag are registered and appear one cycle after the strobe. The error flag is a single-cycle pulse per illegal access, and asserting both strobes together is illegal. Read data is 0 in any cycle that does not follow a legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size code, 2'b00 = one byte |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| bus_err | output | 1 | Registered error pulse |
| pin_in | input | NPORTS*DATA_W (32) | External pin levels, port p in bits 8p+7:8p |
| pin_out | output | NPORTS*DATA_W (32) | Pad output values from the output registers |
| pin_oe | output | NPORTS*DATA_W (32) | Pad output enables from the direction registers |

## Verification
A strobe presented before clock edge k updates the target register at edge k, so pin_out and pin_oe reflect a write right after that edge. The read data and error pulse for the same access are also valid right after edge k, and the bench samples all of them at the following falling edge. A pin change is seen by a read only two edges after it was sampled, so the bench reads once before the change is visible, once at the last stale edge and once when the new value is due. A behavioural model with an associative register store and a queue of pin samples predicts the outputs for every clock and is compared at each falling edge, including during a stretch of random accesses.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;

   // register banks after decode
   typedef enum logic [2:0] {
      BK_OUT  = 3'd0,
      BK_MODE = 3'd1,
      BK_DIR  = 3'd2,
      BK_PIN  = 3'd3,
      BK_SEL2 = 3'd4,
      BK_SEL4 = 3'd5,
      BK_NONE = 3'd6
   } bank_e;

   typedef struct packed {
      logic       hit;
      bank_e      bank;
      logic [1:0] port;
   } dec_t;

   // only legal access size: one byte
   localparam logic [1:0] SZ_BYTE = 2'b00;

   // writable-bit mask of each register; zero for read-only banks
   function automatic logic [7:0] wr_mask(bank_e bank, logic [1:0] port);
      logic [7:0] m;
      m = 8'h00;
      case (bank)
         BK_OUT, BK_DIR: m = (port == 2'd3) ? 8'h03 : 8'hFF;
         BK_MODE: begin
            case (port)
               2'd0, 2'd1: m = 8'h01;
               2'd2:       m = 8'hFF;
               default:    m = 8'h03;
            endcase
         end
         BK_SEL2: m = 8'h03;
         BK_SEL4: m = 8'h0F;
         default: m = 8'h00;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/gpio4_decode.sv
module gpio4_decode
   import gpio4_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic       hi_zero;
   logic [4:0] lo;
   logic       slot;

   generate
      if (ADDR_W < 8) begin : g_bad
         $error("gpio4_decode: ADDR_W must be at least 8");
         assign hi_zero = 1'b0;
      end else if (ADDR_W == 8) begin : g_exact
         assign hi_zero = 1'b1;
      end else begin : g_wide
         assign hi_zero = ~|addr[ADDR_W-1:8];
      end
   endgenerate

   assign lo   = addr[4:0];
   // per-port slots: low offsets 0x0, 0x1, 0x4, 0x5
   assign slot = (lo[4:3] == 2'b00) && !lo[1];

   always_comb begin
      dec.hit  = 1'b0;
      dec.bank = BK_NONE;
      dec.port = {lo[2], lo[0]};
      if (hi_zero) begin
         case (addr[7:5])
            3'd0: if (slot) begin dec.hit = 1'b1; dec.bank = BK_OUT;  end
            3'd1: if (slot) begin dec.hit = 1'b1; dec.bank = BK_MODE; end
            3'd3: if (slot) begin dec.hit = 1'b1; dec.bank = BK_DIR;  end
            3'd4: if (slot) begin dec.hit = 1'b1; dec.bank = BK_PIN;  end
            3'd2: begin
               if (lo == 5'h04) begin dec.hit = 1'b1; dec.bank = BK_SEL2; end
               if (lo == 5'h08) begin dec.hit = 1'b1; dec.bank = BK_SEL4; end
            end
            default: dec.hit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio4_sync: STAGES must be at least 2");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st[k] <= '0;
            else if (k == 0) st[k] <= d;
            else             st[k] <= st[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];

endmodule

// File: rtl/gpio4_port.sv
module gpio4_port #(
   parameter int           W        = 8,
   parameter logic [W-1:0] MODE_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_out,
   input  logic         we_mode,
   input  logic         we_dir,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q_out,
   output logic [W-1:0] q_mode,
   output logic [W-1:0] q_dir
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_out  <= '0;
         q_mode <= MODE_RST;
         q_dir  <= '0;
      end else begin
         if (we_out)  q_out  <= wdata;
         if (we_mode) q_mode <= wdata;
         if (we_dir)  q_dir  <= wdata;
      end
   end
endmodule

// File: rtl/gpio4_regfile.sv
module gpio4_regfile
   import gpio4_pkg::*;
#(
   parameter int           ADDR_W      = 8,
   parameter int           DATA_W      = 8,
   parameter int           NPORTS      = 4,
   parameter int           SYNC_STAGES = 2,
   parameter logic [7:0]   SEL2_RST    = 8'h00,
   parameter logic [7:0]   SEL4_RST    = 8'h0F
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [1:0]               bus_size,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_err,
   input  logic [NPORTS*DATA_W-1:0] pin_in,
   output logic [NPORTS*DATA_W-1:0] pin_out,
   output logic [NPORTS*DATA_W-1:0] pin_oe
);
   localparam int PW = NPORTS * DATA_W;

   generate
      if (DATA_W != 8) begin : g_chk_w
         $error("gpio4_regfile: DATA_W must be 8");
      end
      if (NPORTS != 4) begin : g_chk_n
         $error("gpio4_regfile: NPORTS must be 4");
      end
   endgenerate

   dec_t                           dec;
   logic [DATA_W-1:0]              mask;
   logic                           size_ok, rd_legal, wr_legal, err_d;
   logic [NPORTS-1:0][DATA_W-1:0]  out_q, mode_q, dir_q, pin_q;
   logic [PW-1:0]                  pin_sync;
   logic [DATA_W-1:0]              sel2_q, sel4_q, rmux;

   gpio4_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign mask     = wr_mask(dec.bank, dec.port);
   assign size_ok  = (bus_size == SZ_BYTE);
   assign rd_legal = bus_rd && !bus_wr && size_ok && dec.hit;
   assign wr_legal = bus_wr && !bus_rd && size_ok && dec.hit &&
                     (dec.bank != BK_PIN) && ((bus_wdata & ~mask) == '0);
   assign err_d    = (bus_rd || bus_wr) && !(rd_legal || wr_legal);

   // per-port register sets
   generate
      for (genvar i = 0; i < NPORTS; i++) begin : g_port
         logic sel_me;
         assign sel_me = wr_legal && (dec.port == i[1:0]);
         gpio4_port #(
            .W        (DATA_W),
            .MODE_RST ((i == 2) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
         ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_out  (sel_me && dec.bank == BK_OUT),
            .we_mode (sel_me && dec.bank == BK_MODE),
            .we_dir  (sel_me && dec.bank == BK_DIR),
            .wdata   (bus_wdata),
            .q_out   (out_q[i]),
            .q_mode  (mode_q[i]),
            .q_dir   (dir_q[i])
         );
      end
   endgenerate

   // pin-function select registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel2_q <= SEL2_RST;
         sel4_q <= SEL4_RST;
      end else if (wr_legal) begin
         if (dec.bank == BK_SEL2) sel2_q <= bus_wdata;
         if (dec.bank == BK_SEL4) sel4_q <= bus_wdata;
      end
   end

   gpio4_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );
   assign pin_q = pin_sync;

   always_comb begin
      case (dec.bank)
         BK_OUT:  rmux = out_q[dec.port];
         BK_MODE: rmux = mode_q[dec.port];
         BK_DIR:  rmux = dir_q[dec.port];
         BK_PIN:  rmux = pin_q[dec.port];
         BK_SEL2: rmux = sel2_q;
         BK_SEL4: rmux = sel4_q;
         default: rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rd_legal ? rmux : '0;
         bus_err   <= err_d;
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio4_chk.sv
module gpio4_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NPORTS = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic                     bus_rd,
   input logic                     bus_wr,
   input logic [1:0]               bus_size,
   input logic [DATA_W-1:0]        bus_rdata,
   input logic                     bus_err,
   input logic [NPORTS*DATA_W-1:0] pin_out,
   input logic [NPORTS*DATA_W-1:0] pin_oe
);
   localparam int P3_HI = NPORTS*DATA_W - 1;
   localparam int P3_LO = (NPORTS-1)*DATA_W + 2;

   logic pin_bank;
   assign pin_bank = (bus_addr >= ADDR_W'('h80)) && (bus_addr < ADDR_W'('hA0));

   AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |=> !bus_err); // R12

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R12

   AST_BOTH_STROBES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr) |=> bus_err); // R12

   AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_size != 2'b00) |=> bus_err); // R3

   AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != 2'b00) |=> ($stable(pin_out) && $stable(pin_oe))); // R3

   AST_PIN_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && pin_bank) |=> bus_err); // R7

   AST_PIN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && pin_bank) |=> ($stable(pin_out) && $stable(pin_oe))); // R7

   AST_P3_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out[P3_HI:P3_LO] == '0) && (pin_oe[P3_HI:P3_LO] == '0)); // R5

endmodule

bind gpio4_regfile gpio4_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NPORTS (NPORTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_size  (bus_size),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/sim_gpio4_regfile.sv
module sim_gpio4_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_size = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_err;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio4_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0]  mreg [bit [7:0]];
   logic [31:0] hist [$];
   logic [7:0]  e_rd;
   logic        e_err;

   // mapped?, read-only?, writable mask, pin byte index
   task automatic lookup(input logic [7:0] a, output bit mapped, output bit ro,
                         output logic [7:0] msk, output int pidx);
      mapped = 1; ro = 0; msk = 8'hFF; pidx = 0;
      case (a)
         8'h00, 8'h01, 8'h04, 8'h60, 8'h61, 8'h64, 8'h24: msk = 8'hFF;
         8'h05, 8'h25, 8'h65, 8'h44: msk = 8'h03;
         8'h20, 8'h21: msk = 8'h01;
         8'h48: msk = 8'h0F;
         8'h80: begin ro = 1; pidx = 0; end
         8'h81: begin ro = 1; pidx = 1; end
         8'h84: begin ro = 1; pidx = 2; end
         8'h85: begin ro = 1; pidx = 3; end
         default: mapped = 0;
      endcase
   endtask

   task automatic model_reset();
      bit [7:0] keys [14] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h20, 8'h21, 8'h24,
                              8'h25, 8'h60, 8'h61, 8'h64, 8'h65, 8'h44, 8'h48};
      foreach (keys[i]) mreg[keys[i]] = 8'h00;
      mreg[8'h24] = 8'hFF;
      mreg[8'h48] = 8'h0F;
      hist = '{32'h0, 32'h0};
      e_rd = 8'h00;
      e_err = 1'b0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit mapped, ro;
         logic [7:0] msk;
         int pidx;
         logic [31:0] sv;
         sv = hist[hist.size()-2];
         e_rd = 8'h00;
         e_err = 1'b0;
         if (bus_rd || bus_wr) begin
            lookup(bus_addr, mapped, ro, msk, pidx);
            if ((bus_rd && bus_wr) || bus_size != 2'b00 || !mapped) e_err = 1'b1;
            else if (bus_rd) e_rd = ro ? sv[pidx*8 +: 8] : mreg[bus_addr];
            else if (ro || (bus_wdata & ~msk) != 8'h00) e_err = 1'b1;
            else mreg[bus_addr] = bus_wdata;
         end
         hist.push_back(pin_in);
         if (hist.size() > 4) void'(hist.pop_front());
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && mreg.size() != 0 && !done) begin
         chk(bus_rdata === e_rd, "R12 rdata vs model", {24'h0, bus_rdata}, {24'h0, e_rd});
         chk(bus_err === e_err, "R12 err vs model", {31'h0, bus_err}, {31'h0, e_err});
         chk(pin_out === {mreg[8'h05], mreg[8'h04], mreg[8'h01], mreg[8'h00]},
             "R11 pin_out vs model", pin_out,
             {mreg[8'h05], mreg[8'h04], mreg[8'h01], mreg[8'h00]});
         chk(pin_oe === {mreg[8'h65], mreg[8'h64], mreg[8'h61], mreg[8'h60]},
             "R11 pin_oe vs model", pin_oe,
             {mreg[8'h65], mreg[8'h64], mreg[8'h61], mreg[8'h60]});
      end
   end

   // ---------------- directed stimulus ----------------
   // called at a falling edge; result sampled at the next falling edge
   task automatic access(input bit rd, input bit wr, input logic [7:0] a,
                         input logic [7:0] d, input logic [1:0] sz);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
      access(1, 0, a, 8'h00, 2'b00);
      chk(bus_rdata === exp && bus_err === 1'b0, req, {23'h0, bus_err, bus_rdata},
          {24'h0, exp});
   endtask

   task automatic wr_chk(input logic [7:0] a, input logic [7:0] d,
                         input logic [1:0] sz, input bit exp_err, input string req);
      access(0, 1, a, d, sz);
      chk(bus_err === exp_err, req, {31'h0, bus_err}, {31'h0, exp_err});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R4 reset values
      chk(pin_out === 32'h0 && pin_oe === 32'h0, "R4 pins after reset", pin_out, 32'h0);
      rd_chk(8'h24, 8'hFF, "R4 port2 mode reset");
      rd_chk(8'h21, 8'h00, "R4 port1 mode reset");
      rd_chk(8'h44, 8'h00, "R4 sel2 reset");
      rd_chk(8'h48, 8'h0F, "R4 sel4 reset");
      rd_chk(8'h05, 8'h00, "R4 port3 out reset");

      // R1 / R11 map and pads
      wr_chk(8'h00, 8'hA5, 2'b00, 0, "R1 write out0");
      wr_chk(8'h01, 8'h5A, 2'b00, 0, "R1 write out1");
      wr_chk(8'h04, 8'hC3, 2'b00, 0, "R1 write out2");
      wr_chk(8'h05, 8'h02, 2'b00, 0, "R1 write out3");
      chk(pin_out === 32'h02C35AA5, "R11 pin_out layout", pin_out, 32'h02C35AA5);
      rd_chk(8'h04, 8'hC3, "R1 read out2");
      wr_chk(8'h60, 8'hFF, 2'b00, 0, "R1 write dir0");
      wr_chk(8'h61, 8'h0F, 2'b00, 0, "R1 write dir1");
      wr_chk(8'h64, 8'hF0, 2'b00, 0, "R1 write dir2");
      wr_chk(8'h65, 8'h01, 2'b00, 0, "R1 write dir3");
      chk(pin_oe === 32'h01F00FFF, "R11 pin_oe layout", pin_oe, 32'h01F00FFF);

      // R5 / R9 port 3 masks
      wr_chk(8'h05, 8'h07, 2'b00, 1, "R5 out3 high bit");
      rd_chk(8'h05, 8'h02, "R9 out3 kept after reject");
      wr_chk(8'h25, 8'h80, 2'b00, 1, "R5 mode3 high bit");
      wr_chk(8'h65, 8'hFC, 2'b00, 1, "R5 dir3 high bits");
      chk(pin_oe[31:24] === 8'h01, "R9 dir3 kept", {24'h0, pin_oe[31:24]}, 32'h01);
      wr_chk(8'h25, 8'h03, 2'b00, 0, "R5 mode3 legal");
      rd_chk(8'h25, 8'h03, "R5 mode3 readback");

      // R6 port 0/1 mode masks
      wr_chk(8'h20, 8'h03, 2'b00, 1, "R6 mode0 bit1");
      rd_chk(8'h20, 8'h00, "R9 mode0 unchanged, no partial mask");
      wr_chk(8'h21, 8'h01, 2'b00, 0, "R6 mode1 bit0");
      rd_chk(8'h21, 8'h01, "R6 mode1 readback");
      wr_chk(8'h24, 8'h5A, 2'b00, 0, "R6 mode2 full width");
      rd_chk(8'h24, 8'h5A, "R6 mode2 readback");

      // R7 pin registers read-only
      wr_chk(8'h80, 8'h00, 2'b00, 1, "R7 write pin0");
      wr_chk(8'h85, 8'h12, 2'b00, 1, "R7 write pin3");

      // R8 select masks
      wr_chk(8'h44, 8'h04, 2'b00, 1, "R8 sel2 bit2");
      wr_chk(8'h44, 8'h03, 2'b00, 0, "R8 sel2 legal");
      rd_chk(8'h44, 8'h03, "R8 sel2 readback");
      wr_chk(8'h48, 8'h1F, 2'b00, 1, "R8 sel4 bit4");
      rd_chk(8'h48, 8'h0F, "R9 sel4 kept");
      wr_chk(8'h48, 8'h06, 2'b00, 0, "R8 sel4 legal");
      rd_chk(8'h48, 8'h06, "R8 sel4 readback");

      // R2 unmapped offsets
      access(1, 0, 8'h02, 8'h00, 2'b00);
      chk(bus_err === 1 && bus_rdata === 8'h00, "R2 read 0x02",
          {23'h0, bus_err, bus_rdata}, 32'h100);
      wr_chk(8'h10, 8'hFF, 2'b00, 1, "R2 write 0x10");
      wr_chk(8'h45, 8'h01, 2'b00, 1, "R2 write 0x45");
      wr_chk(8'hFF, 8'h00, 2'b00, 1, "R2 write 0xFF");
      chk(pin_out === 32'h02C35AA5, "R2 pins unchanged", pin_out, 32'h02C35AA5);

      // R3 sizes
      wr_chk(8'h00, 8'h11, 2'b01, 1, "R3 write size 01");
      rd_chk(8'h00, 8'hA5, "R3 out0 kept");
      access(1, 0, 8'h00, 8'h00, 2'b10);
      chk(bus_err === 1 && bus_rdata === 8'h00, "R3 read size 10",
          {23'h0, bus_err, bus_rdata}, 32'h100);

      // R12 error pulse and both strobes
      @(negedge clk);
      chk(bus_err === 0, "R12 error single pulse", {31'h0, bus_err}, 32'h0);
      access(1, 1, 8'h00, 8'h00, 2'b00);
      chk(bus_err === 1, "R12 both strobes", {31'h0, bus_err}, 32'h1);
      @(negedge clk);
      chk(bus_rdata === 8'h00 && bus_err === 0, "R12 idle outputs",
          {23'h0, bus_err, bus_rdata}, 32'h0);

      // R10 two-flop pin sampling
      pin_in = 32'h44332211;
      repeat (3) @(negedge clk);
      rd_chk(8'h80, 8'h11, "R10 pin0");
      rd_chk(8'h81, 8'h22, "R10 pin1");
      rd_chk(8'h84, 8'h33, "R10 pin2");
      rd_chk(8'h85, 8'h44, "R10 pin3");
      pin_in = 32'h44332299;
      rd_chk(8'h80, 8'h11, "R10 stale at first edge");
      rd_chk(8'h80, 8'h11, "R10 stale at second edge");
      rd_chk(8'h80, 8'h99, "R10 new at third edge");

      // random traffic, compared by the model each cycle
      for (int i = 0; i < 600; i++) begin
         logic [7:0] a;
         bit [7:0] picks [20] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h20, 8'h21, 8'h24,
                                  8'h25, 8'h60, 8'h61, 8'h64, 8'h65, 8'h80, 8'h81,
                                  8'h84, 8'h85, 8'h44, 8'h48, 8'h03, 8'h86};
         a = ($urandom_range(0, 9) == 0) ? 8'($urandom) : picks[$urandom_range(0, 19)];
         pin_in = $urandom;
         bus_rd = ($urandom_range(0, 2) == 0);
         bus_wr = ($urandom_range(0, 2) == 0);
         bus_addr = a;
         bus_wdata = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
         bus_size = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         @(negedge clk);
      end
      bus_rd = 0; bus_wr = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule